// File: doc/BRIEF.md
# Racing-Counter Frequency Comparator

This block tells a tracking loop whether a locally generated square wave runs faster or slower than an unknown square wave, using digital logic alone. Each of the two square waves is brought into the system clock domain and reduced to one-cycle rising-edge pulses. Each pulse train advances its own binary counter. The first counter to overflow wins the race. The winner sets or clears a set/reset state bit, and that bit is the verdict. The overflow also restarts both counters, so a new race begins at once.

The verdict is 1 when the unknown wave wins, which tells the loop to raise the local frequency. It is 0 when the local wave wins. There is no "equal" answer. When the two frequencies are close, the restart at each decision hands the lead to whichever wave has its next edge first. The verdict then flips back and forth, and the time before each flip depends on the relative phase of the two waves. A one-cycle strobe marks every decision so that the loop knows when to step.

Top module: `freq_race_cmp`

## Requirements
- R1: A rising edge on either square-wave input reaches the counters through a two-flop synchronizer and an edge detector. A decision caused by an input edge first shows on `raise_o` and `strobe_o` three clock edges after the edge is driven.
- R2: When the local-wave counter overflows and the unknown-wave counter does not, `raise_o` becomes 0 in the next cycle. With 2^CNT_W edges per race, a local wave with the shorter period settles `raise_o` at 0.
- R3: When the unknown-wave counter overflows and the local-wave counter does not, `raise_o` becomes 1 in the next cycle. An unknown wave with the shorter period settles `raise_o` at 1.
- R4: `strobe_o` is high for exactly one cycle per decision, in the same cycle as the verdict update, and is never high two cycles in a row.
- R5: `raise_o` changes only in a cycle where `strobe_o` is high.
- R6: When both counters overflow in the same cycle, a decision is still strobed but `raise_o` keeps its previous value, whether that value is 0 or 1.
- R7: Every decision clears both counters. The next decision needs a full 2^CNT_W further edges from the winner, and an edge that arrives in the clearing cycle is not counted.
- R8: While reset is applied (`rst_n` low, asynchronous, released through two flops), `raise_o` is 1 and `strobe_o` is 0.
- R9: With equal periods and offset phases, the verdict reverses at successive decisions instead of holding a steady value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on the clock |
| syn_sq_i | input | 1 | Locally synthesized square wave, asynchronous to clk |
| unk_sq_i | input | 1 | Unknown square wave, asynchronous to clk |
| raise_o | output | 1 | Verdict: 1 means the unknown is faster (raise the local frequency), 0 means the local wave is faster |
| strobe_o | output | 1 | One-cycle pulse at every decision |

## Verification
The bound checker checks on every cycle how overflow events relate to the outputs. A lone local overflow leads to a 0 verdict, a lone unknown overflow leads to a 1, a simultaneous overflow leaves the verdict unchanged, and the strobe is a single isolated pulse outside of which the verdict never moves. Only the bench's scenarios can show the rest. These are the three-cycle input latency, the exact count of edges per race including edges lost in the clearing cycle, the settled verdict for each pair of unequal periods, the ability of a tie to hold a 0 as well as a 1, and the alternation that appears when equal periods are offset in phase.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int unsigned CH_SYN = 0;
  localparam int unsigned CH_UNK = 1;
  localparam int unsigned N_CH   = 2;

  typedef enum logic [1:0] {
    RACE_NONE = 2'b00,
    RACE_SYN  = 2'b01,
    RACE_UNK  = 2'b10,
    RACE_TIE  = 2'b11
  } race_e;

  function automatic race_e race_classify(input logic syn_won, input logic unk_won);
    race_e r;
    unique case ({unk_won, syn_won})
      2'b01:   r = RACE_SYN;
      2'b10:   r = RACE_UNK;
      2'b11:   r = RACE_TIE;
      default: r = RACE_NONE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fcmp_edge_sync.sv
module fcmp_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] shift_q;
  logic [DEPTH-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[DEPTH-2:0], sig_i};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  // edge seen at the last synchronizer stage, one delay flop behind it
  assign rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/fcmp_race_cnt.sv
module fcmp_race_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic clr_i,
  output logic wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign wrap_o = inc_i && (cnt_q == CNT_MAX);
  assign cnt_en = inc_i | clr_i;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fcmp_verdict.sv
module fcmp_verdict
  import fcmp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ni,
  input  race_e race_i,
  output logic  raise_o,
  output logic  strobe_o
);
  logic raise_q, raise_d, raise_en;
  logic strobe_q, strobe_d;

  always_comb begin
    raise_d  = raise_q;
    raise_en = 1'b0;
    strobe_d = 1'b0;
    unique case (race_i)
      RACE_SYN: begin raise_d = 1'b0; raise_en = 1'b1; strobe_d = 1'b1; end
      RACE_UNK: begin raise_d = 1'b1; raise_en = 1'b1; strobe_d = 1'b1; end
      RACE_TIE: begin strobe_d = 1'b1; end
      default:  begin end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      raise_q  <= 1'b1;
      strobe_q <= 1'b0;
    end else begin
      if (raise_en) raise_q <= raise_d;
      strobe_q <= strobe_d;
    end
  end

  assign raise_o  = raise_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/freq_race_cmp.sv
module freq_race_cmp
  import fcmp_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic syn_sq_i,
  input  logic unk_sq_i,
  output logic raise_o,
  output logic strobe_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_ni;
  logic [N_CH-1:0] sq_in;
  logic [N_CH-1:0] rise;
  logic [N_CH-1:0] wrap;
  logic            clear_all;
  logic            wrap_syn;
  logic            wrap_unk;
  race_e           race;

  // asynchronous assert, clocked release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign sq_in[CH_SYN] = syn_sq_i;
  assign sq_in[CH_UNK] = unk_sq_i;

  genvar g;
  generate
    for (g = 0; g < N_CH; g++) begin : g_ch
      fcmp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_ni (rst_ni),
        .sig_i  (sq_in[g]),
        .rise_o (rise[g])
      );
      fcmp_race_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_ni (rst_ni),
        .inc_i  (rise[g]),
        .clr_i  (clear_all),
        .wrap_o (wrap[g])
      );
    end
  endgenerate

  assign wrap_syn  = wrap[CH_SYN];
  assign wrap_unk  = wrap[CH_UNK];
  assign clear_all = |wrap;
  assign race      = race_classify(wrap_syn, wrap_unk);

  fcmp_verdict u_verdict (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .race_i   (race),
    .raise_o  (raise_o),
    .strobe_o (strobe_o)
  );
endmodule

// File: rtl/fcmp_checker.sv
module fcmp_checker (
  input logic clk,
  input logic rst_ni,
  input logic wrap_syn,
  input logic wrap_unk,
  input logic raise,
  input logic strobe
);
  p_syn_wins_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (wrap_syn && !wrap_unk) |=> !raise);

  p_unk_wins_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (wrap_unk && !wrap_syn) |=> raise);

  p_strobe_on_event_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (wrap_syn || wrap_unk) |=> strobe);

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    strobe |=> !strobe);

  p_quiet_hold_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    !strobe |-> $stable(raise));

  p_tie_hold_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wrap_syn && wrap_unk) |=> $stable(raise));
endmodule

bind freq_race_cmp fcmp_checker u_chk (
  .clk      (clk),
  .rst_ni   (rst_ni),
  .wrap_syn (wrap_syn),
  .wrap_unk (wrap_unk),
  .raise    (raise_o),
  .strobe   (strobe_o)
);

// File: tb/freq_race_cmp_tb.sv
module freq_race_cmp_tb;
  localparam int CLK_P = 10;
  localparam int W     = 3;
  localparam int MAXC  = (1 << W) - 1;

  logic clk, rst_n, syn, unk, raise, strobe;

  int total, bad;
  bit done;

  int mcs, mcu;
  bit mps, mpu, mv;
  bit ev[3];
  bit es[3];
  int n_strobe, n_flip;
  bit last_raise;

  freq_race_cmp #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .syn_sq_i(syn), .unk_sq_i(unk),
    .raise_o(raise), .strobe_o(strobe)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; syn = 1'b0; unk = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mcs = 0; mcu = 0; mps = 0; mpu = 0; mv = 1'b1;
    for (int i = 0; i < 3; i++) begin ev[i] = 1'b1; es[i] = 1'b0; end
    last_raise = raise;
  endtask

  task automatic step(input bit s, input bit u, input string tag);
    bit rs, ru, ws, wu, st;
    // R1 R4 R7: strobe follows the arithmetic race model three edges later
    check({tag, " R1 R4 R7 strobe"}, strobe, es[2]);
    // R5: verdict follows the model, changing only at decisions
    check({tag, " R1 R5 verdict"}, raise, ev[2]);
    if (strobe) n_strobe++;
    if (raise != last_raise) n_flip++;
    last_raise = raise;
    syn = s; unk = u;
    rs = s & ~mps; ru = u & ~mpu;
    mps = s; mpu = u;
    ws = rs && (mcs == MAXC);
    wu = ru && (mcu == MAXC);
    st = ws | wu;
    if (st) begin
      if (ws && !wu) mv = 1'b0;
      else if (wu && !ws) mv = 1'b1;
      mcs = 0; mcu = 0;
    end else begin
      if (rs) mcs++;
      if (ru) mcu++;
    end
    ev[2] = ev[1]; ev[1] = ev[0]; ev[0] = mv;
    es[2] = es[1]; es[1] = es[0]; es[0] = st;
    @(negedge clk);
  endtask

  task automatic run(input int ps, input int pu, input int os, input int ou,
                     input int n, input string tag);
    for (int t = 0; t < n; t++)
      step(((t + os) % ps) < (ps / 2), ((t + ou) % pu) < (pu / 2), tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit v0;
    total = 0; bad = 0; done = 0;
    n_strobe = 0; n_flip = 0;
    rst_n = 1'b0; syn = 1'b0; unk = 1'b0;
    @(negedge clk);
    // R8: reset state
    check("R8 raise in reset", raise, 1);
    check("R8 strobe in reset", strobe, 0);
    do_reset();
    check("R8 raise after release", raise, 1);
    check("R8 strobe after release", strobe, 0);

    // R2 R3: sweep unequal periods, the shorter period settles the verdict
    for (int ps = 2; ps <= 6; ps++) begin
      for (int pu = 2; pu <= 6; pu++) begin
        if (ps != pu) begin
          do_reset();
          n_strobe = 0;
          run(ps, pu, 0, 0, 260, "R2 R3 sweep");
          if (ps < pu) check("R2 settled verdict local faster", raise, 0);
          else         check("R3 settled verdict unknown faster", raise, 1);
          check("R4 decisions occurred", (n_strobe > 0) ? 1 : 0, 1);
        end
      end
    end

    // R6: simultaneous overflow keeps 1 from reset
    do_reset();
    n_strobe = 0;
    run(4, 4, 0, 0, 200, "R6 tie");
    check("R6 tie keeps 1", raise, 1);
    check("R6 tie strobes", (n_strobe > 0) ? 1 : 0, 1);
    // drive the verdict to 0, then tie again: it must keep 0
    run(2, 5, 0, 0, 200, "R2 pre-tie");
    check("R2 local faster gives 0", raise, 0);
    run(3, 3, 0, 0, 150, "R6 tie");
    v0 = raise;
    n_strobe = 0;
    run(3, 3, 0, 0, 150, "R6 tie");
    check("R6 tie keeps prior verdict", raise, v0);
    check("R6 tie keeps 0", raise, 0);
    check("R6 tie still strobes", (n_strobe > 0) ? 1 : 0, 1);

    // R9: equal periods with phase offset alternate the verdict
    do_reset();
    n_flip = 0;
    run(4, 4, 2, 0, 200, "R9 offset");
    check("R9 verdict alternates", (n_flip >= 2) ? 1 : 0, 1);
    n_flip = 0;
    run(6, 6, 0, 3, 300, "R9 offset");
    check("R9 verdict alternates wide", (n_flip >= 2) ? 1 : 0, 1);

    // R7: from reset exactly 2^W unknown edges make one decision
    do_reset();
    n_strobe = 0;
    run(1000, 4, 500, 0, 4 * (MAXC + 1) - 1, "R7 count");
    check("R7 no decision before last edge lands", n_strobe, 0);
    run(1000, 4, 500, 0, 6, "R7 count");
    check("R7 one decision after 2^W edges", n_strobe, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule